// File: doc/BRIEF.md
# I2C Bus-Lock Recovery Pulser

This block frees an I2C bus when a target has stopped partway through a byte and is holding SDA low. Software loads a 4-bit pulse count, then raises a one-cycle request. The block releases SDA and clocks SCL low and high that many times, so the stuck target can shift out the rest of its byte and let go of SDA. After the last pulse it drives a stop condition, which returns every target to idle. The busy flag then clears by itself.

The block also brings both bus lines to software through a two-bit monitor. Each line passes through a two-flop synchronizer. SDA then goes through a stability filter that ignores short spikes. The filter delays every SDA edge, and that delay also slows repeated-start signalling, so a bypass input routes the synchronized SDA around it.

The pad outputs use open-drain form: asserting an `*_oe` pin pulls the line low, and deasserting it releases the line. None of the pins carries a data stream, so there is no valid/ready handshake. All pins are plain level control and status.

Top module: `i2c_unstick`

## Requirements
- R1: After reset `busy`, `scl_oe` and `sda_oe` are 0, and `busy` stays 0 until a request is accepted.
- R2: A request accepted in idle with `pulse_cnt` = N (N > 0) produces exactly N SCL low pulses. Each pulse holds `scl_oe` at 1 for one half-period and then at 0 for one half-period. `sda_oe` stays 0 for the whole pulse train.
- R3: A request with `pulse_cnt` = 0 produces no pulse and no stop condition, and `busy` stays 0.
- R4: After the last pulse a stop condition follows, each step lasting one half-period, in this order:
  - SCL and SDA both pulled low.
  - SCL released while SDA is still low.
  - Both lines released.
  
  `busy` then clears. The whole sequence keeps `busy` high for exactly (2N+3) half-periods, and `sda_oe` is high for exactly 2 half-periods.
- R5: While `busy` is 1, a new request is ignored. Any change to `pulse_cnt` during that time does not alter the running sequence, because the count is captured when the request is accepted.
- R6: `bus_mon` bit 0 gives the SDA level and bit 1 gives the SCL level, where 0 means the line is low. A change on `scl_in` appears on `bus_mon[1]` two clock edges later.
- R7: With `filt_bypass` = 0, a new SDA level reaches `bus_mon[0]` exactly FILT_LEN+2 edges after it is applied to `sda_in`. An SDA spike shorter than FILT_LEN cycles never reaches `bus_mon[0]`.
- R8: With `filt_bypass` = 1, an SDA change reaches `bus_mon[0]` two edges after it is applied.
- R9: The half-period is HALF_FAST clocks when `fast_mode` = 1 and HALF_STD clocks when `fast_mode` = 0. The value is chosen at the start of each phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 1 | One-cycle recovery request |
| pulse_cnt | input | CNT_W | Number of SCL pulses per request |
| fast_mode | input | 1 | Selects the short half-period |
| filt_bypass | input | 1 | Routes synchronized SDA around the filter |
| scl_in | input | 1 | Raw SCL pad level |
| sda_in | input | 1 | Raw SDA pad level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Request in progress; clears by itself |
| bus_mon | output | 2 | {SCL, filtered SDA} levels |

## Verification
The hardest case to reach from the ports is a second request that arrives, carrying a different count, in the middle of a running sequence. The bench therefore raises `req_set` with count 7 halfway through a two-pulse run and checks that the busy length and pulse count still match N = 2. The filter's rejection edge is also delicate. The bench applies an SDA spike one cycle shorter than the stable window and checks that `bus_mon[0]` never moves. It then applies a long change and checks the exact edge on which that change arrives.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LO,
    PH_HI,
    PH_STOP_LL,
    PH_STOP_HL,
    PH_STOP_HH
  } phase_t;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i] <= 1'b1;
        q[i]  <= 1'b1;
      end else begin
        s1[i] <= d[i];
        q[i]  <= s1[i];
      end
    end
  end
endmodule

// File: rtl/i2cr_glitch.sv
module i2cr_glitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic d,
  output logic q
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_LEN - 1);

  logic          held;
  logic [FW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b1;
      run  <= '0;
    end else if (d == held) begin
      run <= '0;
    end else if (run == LAST) begin
      held <= d;
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign q = bypass ? d : held;

  AST_FILT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held) |-> $past(run) == LAST); // R7
endmodule

// File: rtl/i2cr_seq.sv
module i2cr_seq
  import i2cr_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int HALF_STD  = 10,
  parameter int HALF_FAST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic             fast_mode,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy
);
  localparam int HMAX = (HALF_STD > HALF_FAST) ? HALF_STD : HALF_FAST;
  localparam int TW   = $clog2(HMAX + 1);

  phase_t           ph;
  logic [TW-1:0]    tick;
  logic [CNT_W-1:0] left;
  logic [TW-1:0]    half_m1;

  assign half_m1 = fast_mode ? TW'(HALF_FAST - 1) : TW'(HALF_STD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      tick <= '0;
      left <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (req_set && pulse_cnt != '0) begin
          ph   <= PH_LO;
          left <= pulse_cnt;
          tick <= half_m1;
        end
        PH_LO: if (tick == '0) begin
          ph   <= PH_HI;
          left <= left - 1'b1;
          tick <= half_m1;
        end else tick <= tick - 1'b1;
        PH_HI: if (tick == '0) begin
          ph   <= (left == '0) ? PH_STOP_LL : PH_LO;
          tick <= half_m1;
        end else tick <= tick - 1'b1;
        PH_STOP_LL: if (tick == '0) begin
          ph   <= PH_STOP_HL;
          tick <= half_m1;
        end else tick <= tick - 1'b1;
        PH_STOP_HL: if (tick == '0) begin
          ph   <= PH_STOP_HH;
          tick <= half_m1;
        end else tick <= tick - 1'b1;
        PH_STOP_HH: if (tick == '0) ph <= PH_IDLE;
                    else tick <= tick - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (ph != PH_IDLE);
  assign scl_oe = (ph == PH_LO) || (ph == PH_STOP_LL);
  assign sda_oe = (ph == PH_STOP_LL) || (ph == PH_STOP_HL);

  AST_LEFT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> left <= $past(left)); // R5
  AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_oe); // R4
  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe); // R4
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
  parameter int CNT_W     = 4,
  parameter int HALF_STD  = 10,
  parameter int HALF_FAST = 4,
  parameter int FILT_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic             fast_mode,
  input  logic             filt_bypass,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic [1:0]       bus_mon
);
  logic [1:0] synced;
  logic       sda_clean;

  i2cr_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(synced)
  );

  i2cr_glitch #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .bypass(filt_bypass), .d(synced[0]), .q(sda_clean)
  );

  i2cr_seq #(.CNT_W(CNT_W), .HALF_STD(HALF_STD), .HALF_FAST(HALF_FAST)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .pulse_cnt(pulse_cnt),
    .fast_mode(fast_mode), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy)
  );

  assign bus_mon = {synced[1], sda_clean};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R1
  AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> busy); // R2
endmodule

// File: tb/sim_i2c_unstick.sv
module sim_i2c_unstick;
  localparam int HS = 10, HF = 4, FL = 4;
  logic clk = 0, rst_n = 0, req_set = 0, fast_mode = 0, filt_bypass = 0;
  logic scl_in = 1, sda_in = 1;
  logic [3:0] pulse_cnt = 0;
  logic scl_oe, sda_oe, busy;
  logic [1:0] bus_mon;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_unstick #(.CNT_W(4), .HALF_STD(HS), .HALF_FAST(HF), .FILT_LEN(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .pulse_cnt(pulse_cnt),
    .fast_mode(fast_mode), .filt_bypass(filt_bypass), .scl_in(scl_in),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .bus_mon(bus_mon));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one request; optional second request mid-sequence (R5)
  task automatic run_req(int n, bit fast, bit rereq);
    int h, bcyc, lows, lowcyc, sdacyc, sda_bad;
    bit prev_scl;
    h = fast ? HF : HS;
    fast_mode = fast;
    @(negedge clk);
    pulse_cnt = 4'(n); req_set = 1;
    @(negedge clk);
    req_set = 0;
    bcyc = 0; lows = 0; lowcyc = 0; sdacyc = 0; sda_bad = 0; prev_scl = 0;
    while (busy && bcyc < 2000) begin
      bcyc++;
      if (scl_oe && !prev_scl) lows++;
      if (scl_oe) lowcyc++;
      if (sda_oe) sdacyc++;
      if (sda_oe && lows < n + 1) sda_bad++;
      prev_scl = scl_oe;
      if (rereq && bcyc == 2 * h) begin pulse_cnt = 4'd7; req_set = 1; end
      else req_set = 0;
      @(negedge clk);
    end
    req_set = 0;
    if (n == 0) begin
      chk("R3 busy cycles", bcyc, 0);
      chk("R3 scl_oe idle", int'(scl_oe), 0);
    end else begin
      chk(rereq ? "R5 busy length" : "R4 busy length", bcyc, (2 * n + 3) * h);
      chk("R2 low pulses + stop", lows, n + 1);
      chk(fast ? "R9 low cycles fast" : "R9 low cycles std", lowcyc, (n + 1) * h);
      chk("R4 sda_oe cycles", sdacyc, 2 * h);
      chk("R2 sda released during pulses", sda_bad, 0);
    end
    chk("R1 idle outputs", int'({scl_oe, sda_oe, busy}), 0);
  endtask

  task automatic test_reset;
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 scl_oe at reset", int'(scl_oe), 0);
    chk("R1 sda_oe at reset", int'(sda_oe), 0);
    chk("R6 monitor idle high", int'(bus_mon), 3);
  endtask

  task automatic test_scl_mon;
    @(negedge clk); scl_in = 0;
    @(negedge clk); chk("R6 scl after 1 edge", int'(bus_mon[1]), 1);
    @(negedge clk); chk("R6 scl after 2 edges", int'(bus_mon[1]), 0);
    scl_in = 1;
    repeat (3) @(negedge clk);
    chk("R6 scl back high", int'(bus_mon[1]), 1);
  endtask

  task automatic test_filter;
    filt_bypass = 0;
    @(negedge clk); sda_in = 0;
    repeat (FL + 1) @(negedge clk);
    chk("R7 sda before window", int'(bus_mon[0]), 1);
    @(negedge clk);
    chk("R7 sda at FILT_LEN+2", int'(bus_mon[0]), 0);
    sda_in = 1;
    repeat (FL + 4) @(negedge clk);
    chk("R7 sda back high", int'(bus_mon[0]), 1);
    // short spike of FL-1 cycles
    sda_in = 0;
    repeat (FL - 1) @(negedge clk);
    sda_in = 1;
    begin
      int seen = 0;
      for (int i = 0; i < FL + 6; i++) begin
        if (!bus_mon[0]) seen++;
        @(negedge clk);
      end
      chk("R7 spike suppressed", seen, 0);
    end
  endtask

  task automatic test_bypass;
    filt_bypass = 1;
    @(negedge clk); sda_in = 0;
    @(negedge clk); chk("R8 bypass after 1 edge", int'(bus_mon[0]), 1);
    @(negedge clk); chk("R8 bypass after 2 edges", int'(bus_mon[0]), 0);
    sda_in = 1;
    repeat (2) @(negedge clk);
    chk("R8 bypass back high", int'(bus_mon[0]), 1);
    filt_bypass = 0;
    repeat (FL + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    run_req(1, 0, 0);
    run_req(3, 1, 0);
    run_req(9, 0, 0);
    run_req(15, 1, 0);
    run_req(0, 0, 0);
    run_req(2, 0, 1);
    test_scl_mon();
    test_filter();
    test_bypass();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule